// File: doc/BRIEF.md
# Bus Transfer Sizing Sequencer

This block sits between an internal requester and a synchronous external bus on which it is always the master. It accepts a single access request: an address, a size (byte, word, longword or 16-byte line), a direction and, for writes, the data. It then runs that request as one or more external bus cycles. The number of cycles depends on the width of the port being addressed (8, 16 or 32 bits) and on how the address is aligned.

For each bus cycle the sequencer drives the address, a two-bit size code and the read/write attribute. It raises a start strobe for one clock and keeps everything steady until the slave acknowledges. Write bytes go out on the byte lanes the port expects. Read bytes coming back on those lanes are gathered into the original request layout, and a single done pulse returns them.

Top module: `bus_sizer`

## Requirements
- R1: The size code on `busSiz` is 2'b01 for one byte, 2'b10 for two bytes, 2'b00 for four bytes and 2'b11 for a 16-byte line. Each bus cycle moves 1, 2 or 4 bytes.
- R2: The port width is set by `portSel` (2'b00 = 32-bit, 2'b01 = 8-bit, 2'b10 = 16-bit). Starting at the request address, each cycle moves the largest of 4, 2 or 1 bytes that is no more than the bytes still left and no more than the port width, and whose size divides the cycle address. A longword at offset 1 on a 32-bit port therefore runs as a byte at +1, then a word at +2, then a byte at +4.
- R3: When the request address is a multiple of the request size, the first cycle shows the request's own size code. The later cycles show their own piece size. A longword to an 8-bit port gives 2'b00 and then 2'b01 three times. A line to a 32-bit port gives 2'b11 and then 2'b00.
- R4: `busTs` is high for exactly one clock, the first clock of every bus cycle. The first cycle of a request starts in the clock after the request is accepted.
- R5: Address, size code and `busRnw` hold steady until `busAck` is sampled high in a clock after the start clock. `busAck` is ignored during the start clock. After an acknowledge, the next read cycle starts in the following clock, and the next write cycle starts one clock later.
- R6: A byte at address A travels on lane (A mod port bytes), which is bits [8L+7:8L] of the 32-bit data bus. Lanes not carrying the piece are driven as zero. Write data stays unchanged for the clock after the acknowledge.
- R7: Byte i of a request (address `reqAddr`+i) sits at bits [8i+7:8i] of `reqWData` and of `doneRData`. Bytes beyond the request size read as zero. `done` is high for one clock, in the clock after the final acknowledge.
- R8: `busy` is high from the clock after acceptance until the final acknowledge. A `reqValid` seen while `busy` is high starts nothing.
- R9: With `busAck` held high, every bus cycle lasts two clocks. A read request of N cycles then gives `done` 2N+1 clocks after the accepting edge's clock, and a write request of N cycles gives it 3N clocks after.
- R10: Synchronous active-high `rst` returns the sequencer to idle, with `busTs`, `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqAddr | input | ADDR_W | Request byte address |
| reqSize | input | 2 | Request size code (R1 encoding) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWData | input | 128 | Write bytes, byte i at bits [8i+7:8i] |
| portSel | input | 2 | Port width select |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| doneRData | output | 128 | Assembled read bytes |
| busAddr | output | ADDR_W | Bus cycle address |
| busSiz | output | 2 | Bus cycle size code |
| busRnw | output | 1 | 1 = read cycle |
| busTs | output | 1 | Bus cycle start strobe |
| busWData | output | 32 | Write data lanes |
| busRData | input | 32 | Read data lanes |
| busAck | input | 1 | Synchronous transfer acknowledge |

## Verification
Each result has a fixed arrival clock. The start strobe comes one clock after acceptance. A cycle ends on the first acknowledge sampled after its start clock. The next read starts in the clock after that acknowledge, and the next write one clock later. `done` follows the final acknowledge by one clock. The bench drives and samples only on falling edges and acts as a slave that counts edges from each start strobe: it asserts the acknowledge after a chosen number of wait clocks, or holds it high for fast termination. At every falling edge it checks the strobe, the held attributes, the data hold clock and the exact clock of `done` against those counts.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;
  localparam int BUS_BYTES  = 4;
  localparam int LINE_BYTES = 16;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } sizCode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic accept;  // latch a new request
    logic take;    // current bus cycle acknowledged
    logic inCyc;   // a bus cycle is on the bus
  } ctrlStrobe_t;

  function automatic logic [4:0] codeBytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: codeBytes = 5'd1;
      SZ_WORD: codeBytes = 5'd2;
      SZ_LONG: codeBytes = 5'd4;
      default: codeBytes = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/bus_sizer_ctrl.sv
module bus_sizer_ctrl
  import bus_sizer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        busAck,
  input  logic        lastPiece,
  input  logic        isWrite,
  output ctrlStrobe_t strobe,
  output logic        busTs,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_CYC, ST_GAP} state_e;

  state_e state;
  logic   tsQ;
  logic   doneQ;

  always_comb begin
    strobe.accept = (state == ST_IDLE) && reqValid;
    strobe.take   = (state == ST_CYC) && busAck && !tsQ;
    strobe.inCyc  = (state == ST_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tsQ   <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      tsQ   <= 1'b0;
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_CYC;
          tsQ   <= 1'b1;
        end
        ST_CYC: if (busAck && !tsQ) begin
          if (lastPiece) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else if (isWrite) begin
            state <= ST_GAP;
          end else begin
            tsQ <= 1'b1;
          end
        end
        default: begin
          state <= ST_CYC;
          tsQ   <= 1'b1;
        end
      endcase
    end
  end

  assign busTs = tsQ;
  assign busy  = (state != ST_IDLE);
  assign done  = doneQ;
endmodule

// File: rtl/bus_sizer_data.sv
module bus_sizer_data
  import bus_sizer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctrlStrobe_t               strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqSize,
  input  logic                      reqWrite,
  input  logic [8*LINE_BYTES-1:0]   reqWData,
  input  logic [1:0]                portSel,
  input  logic [8*BUS_BYTES-1:0]    busRData,
  output logic [ADDR_W-1:0]         busAddr,
  output logic [1:0]                busSiz,
  output logic                      busRnw,
  output logic [8*BUS_BYTES-1:0]    busWData,
  output logic [8*LINE_BYTES-1:0]   doneRData,
  output logic                      lastPiece,
  output logic                      isWrite
);
  localparam int LW = 8 * LINE_BYTES;
  localparam int BW = 8 * BUS_BYTES;

  logic [1:0]        sizeQ, portQ;
  logic              wrQ, firstQ, alignQ;
  logic [LW-1:0]     wBuf, rBuf;
  logic [ADDR_W-1:0] curAddr;
  logic [3:0]        idx;
  logic [4:0]        remain;
  logic [BW-1:0]     wComb, wdHold;

  logic [2:0] portBytes, pieceBytes;
  logic [1:0] laneBase;
  logic [1:0] pieceCode;
  logic [4:0] reqBytes;
  logic [BUS_BYTES-1:0] laneHit;
  logic [3:0] laneSrc [BUS_BYTES];

  always_comb begin
    case (portQ)
      2'b01:   portBytes = 3'd1;
      2'b10:   portBytes = 3'd2;
      default: portBytes = 3'd4;
    endcase
    if (portBytes == 3'd4 && curAddr[1:0] == 2'b00 && remain >= 5'd4)
      pieceBytes = 3'd4;
    else if (portBytes >= 3'd2 && !curAddr[0] && remain >= 5'd2)
      pieceBytes = 3'd2;
    else
      pieceBytes = 3'd1;
    case (pieceBytes)
      3'd4:    pieceCode = SZ_LONG;
      3'd2:    pieceCode = SZ_WORD;
      default: pieceCode = SZ_BYTE;
    endcase
    laneBase = curAddr[1:0] & (portBytes[1:0] - 2'd1);
    reqBytes = codeBytes(reqSize);
  end

  for (genvar L = 0; L < BUS_BYTES; L++) begin : g_lane
    logic [2:0] rel;
    assign rel        = 3'(L) - {1'b0, laneBase};
    assign laneHit[L] = (3'(L) >= {1'b0, laneBase}) && (rel < pieceBytes);
    assign laneSrc[L] = idx + {2'b00, rel[1:0]};
    assign wComb[8*L +: 8] = laneHit[L] ? wBuf[8*laneSrc[L] +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sizeQ   <= '0;
      portQ   <= '0;
      wrQ     <= 1'b0;
      firstQ  <= 1'b0;
      alignQ  <= 1'b0;
      wBuf    <= '0;
      rBuf    <= '0;
      curAddr <= '0;
      idx     <= '0;
      remain  <= '0;
      wdHold  <= '0;
    end else begin
      if (strobe.accept) begin
        sizeQ   <= reqSize;
        portQ   <= portSel;
        wrQ     <= reqWrite;
        wBuf    <= reqWData;
        rBuf    <= '0;
        curAddr <= reqAddr;
        idx     <= '0;
        remain  <= reqBytes;
        firstQ  <= 1'b1;
        alignQ  <= (reqAddr[3:0] & (reqBytes[3:0] - 4'd1)) == 4'd0;
      end
      if (strobe.take) begin
        curAddr <= curAddr + ADDR_W'(pieceBytes);
        idx     <= idx + {1'b0, pieceBytes};
        remain  <= remain - {2'b00, pieceBytes};
        firstQ  <= 1'b0;
        for (int L = 0; L < BUS_BYTES; L++)
          if (laneHit[L]) rBuf[8*laneSrc[L] +: 8] <= busRData[8*L +: 8];
      end
      if (strobe.inCyc) wdHold <= wComb;
    end
  end

  assign busAddr   = curAddr;
  assign busSiz    = (firstQ && alignQ) ? sizeQ : pieceCode;
  assign busRnw    = !wrQ;
  assign busWData  = strobe.inCyc ? wComb : wdHold;
  assign doneRData = rBuf;
  assign lastPiece = (remain == {2'b00, pieceBytes});
  assign isWrite   = wrQ;
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bus_sizer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqSize,
  input  logic                    reqWrite,
  input  logic [8*LINE_BYTES-1:0] reqWData,
  input  logic [1:0]              portSel,
  output logic                    busy,
  output logic                    done,
  output logic [8*LINE_BYTES-1:0] doneRData,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [1:0]              busSiz,
  output logic                    busRnw,
  output logic                    busTs,
  output logic [8*BUS_BYTES-1:0]  busWData,
  input  logic [8*BUS_BYTES-1:0]  busRData,
  input  logic                    busAck
);
  ctrlStrobe_t strobe;
  logic        lastPiece;
  logic        isWrite;

  bus_sizer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .busAck    (busAck),
    .lastPiece (lastPiece),
    .isWrite   (isWrite),
    .strobe    (strobe),
    .busTs     (busTs),
    .busy      (busy),
    .done      (done)
  );

  bus_sizer_data #(.ADDR_W(ADDR_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqWData  (reqWData),
    .portSel   (portSel),
    .busRData  (busRData),
    .busAddr   (busAddr),
    .busSiz    (busSiz),
    .busRnw    (busRnw),
    .busWData  (busWData),
    .doneRData (doneRData),
    .lastPiece (lastPiece),
    .isWrite   (isWrite)
  );
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk
  import bus_sizer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input ctrlStrobe_t            strobe,
  input logic                   busy,
  input logic                   done,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [1:0]             busSiz,
  input logic                   busRnw,
  input logic                   busTs,
  input logic [8*BUS_BYTES-1:0] busWData,
  input logic                   busAck
);
  // R4
  ts_single_chk: assert property (@(posedge clk) disable iff (rst)
    busTs |=> !busTs);

  // R4
  ts_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> busTs);

  // R5
  attr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.inCyc && !(busAck && !busTs)) |=>
      (strobe.inCyc && $stable(busAddr) && $stable(busSiz) && $stable(busRnw)));

  // R5
  ack_in_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busTs && busAck) |=> strobe.inCyc);

  // R6
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.take && !busRnw) |=> $stable(busWData));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busTs && !busy && !done));
endmodule

bind bus_sizer bus_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .strobe   (strobe),
  .busy     (busy),
  .done     (done),
  .busAddr  (busAddr),
  .busSiz   (busSiz),
  .busRnw   (busRnw),
  .busTs    (busTs),
  .busWData (busWData),
  .busAck   (busAck)
);

// File: tb/tb_bus_sizer.sv
module tb_bus_sizer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reqValid = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic [1:0]   reqSize = '0;
  logic         reqWrite = 1'b0;
  logic [127:0] reqWData = '0;
  logic [1:0]   portSel = '0;
  logic         busy, done, busRnw, busTs;
  logic [127:0] doneRData;
  logic [31:0]  busAddr, busWData;
  logic [1:0]   busSiz;
  logic [31:0]  busRData = '0;
  logic         busAck = 1'b0;

  bus_sizer dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWData(reqWData),
    .portSel(portSel), .busy(busy), .done(done), .doneRData(doneRData),
    .busAddr(busAddr), .busSiz(busSiz), .busRnw(busRnw), .busTs(busTs),
    .busWData(busWData), .busRData(busRData), .busAck(busAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  // bench memory and expected piece list
  logic [7:0]  mem [64];
  logic [7:0]  curData [16];
  logic [31:0] expA [32];
  int          expS [32];
  logic [1:0]  expCode [32];
  int          expN, curPb, reqNo;
  bit          curWr, fastMode;

  // slave state
  bit          slvActive = 0, ackQ = 0, tsPrev = 0;
  int          slvIdx = 0, cnt = 0, pS = 0;
  logic [31:0] pA, capW, baseAddr;
  logic [1:0]  pSiz;

  always @(negedge clk) begin
    if (rst) begin
      slvActive = 0; ackQ = 0; tsPrev = 0; busAck = 1'b0;
    end else begin
      if (slvActive && ackQ && !tsPrev) begin
        if (curWr) begin
          chk(busWData == capW, "R6 data hold after ack", busWData, capW);
          for (int j = 0; j < pS; j++)
            mem[(pA + j) & 63] = capW[8*((pA + j) % curPb) +: 8];
        end
        slvActive = 0;
        if (slvIdx < expN)
          chk(busTs == !curWr, "R5 next cycle start clock", busTs, !curWr);
      end
      if (busTs) begin
        chk(!tsPrev, "R4 start strobe width", tsPrev, 0);
        chk(!slvActive, "R5 start before ack", slvActive, 0);
        if (slvIdx < expN) begin
          logic [31:0] ew;
          int k;
          k = slvIdx;
          chk(busAddr == expA[k], "R2 cycle address", busAddr, expA[k]);
          chk(busSiz == expCode[k], "R1 R3 size code", busSiz, expCode[k]);
          chk(busRnw == !curWr, "R5 direction", busRnw, !curWr);
          if (curWr) begin
            ew = '0;
            for (int j = 0; j < expS[k]; j++)
              ew[8*((expA[k] + j) % curPb) +: 8] = curData[expA[k] + j - baseAddr];
            chk(busWData == ew, "R6 write lanes", busWData, ew);
          end
          pS = expS[k];
        end else begin
          chk(0, "R8 unexpected bus cycle", busAddr, 0);
          pS = 1;
        end
        pA = busAddr; pSiz = busSiz; capW = busWData;
        cnt = (slvIdx + reqNo) % 3;
        slvIdx++;
        slvActive = 1;
        ackQ = fastMode;
      end else if (slvActive) begin
        chk(busAddr == pA && busSiz == pSiz, "R5 attributes held",
            {busSiz, busAddr}, {pSiz, pA});
        if (fastMode || cnt == 0) ackQ = 1;
        else begin cnt--; ackQ = 0; end
      end else begin
        ackQ = fastMode;
      end
      busAck = ackQ;
      for (int L = 0; L < 4; L++) begin
        logic [31:0] la;
        if (slvActive && L < curPb) begin
          la = (pA & ~(curPb - 1)) + L;
          busRData[8*L +: 8] = (la >= pA && la < pA + pS) ? mem[la & 63] : 8'h5A;
        end else begin
          busRData[8*L +: 8] = 8'hC3;
        end
      end
      tsPrev = busTs;
    end
  end

  function automatic int sizeOf(input int code);
    case (code)
      1: return 1;
      2: return 2;
      0: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic logic [1:0] codeOf(input int n);
    case (n)
      1: return 2'b01;
      2: return 2'b10;
      4: return 2'b00;
      default: return 2'b11;
    endcase
  endfunction

  task automatic runReq(input int port, input int size, input int off, input bit wr);
    int n, a, rem, t, s;
    logic [127:0] expR, wd;
    n = sizeOf(size);
    curPb = (port == 1) ? 1 : (port == 2) ? 2 : 4;
    baseAddr = 32'h0000_1010 + off;
    a = baseAddr; rem = n; expN = 0;
    while (rem > 0) begin
      if (curPb == 4 && a % 4 == 0 && rem >= 4) s = 4;
      else if (curPb >= 2 && a % 2 == 0 && rem >= 2) s = 2;
      else s = 1;
      expA[expN] = a; expS[expN] = s;
      expCode[expN] = (expN == 0 && baseAddr % n == 0) ? codeOf(n) : codeOf(s);
      expN++; a += s; rem -= s;
    end
    wd = '0; expR = '0;
    for (int i = 0; i < n; i++) begin
      curData[i] = 8'((reqNo * 29 + i * 11 + 3) & 255);
      wd[8*i +: 8] = curData[i];
      expR[8*i +: 8] = mem[(baseAddr + i) & 63];
    end
    curWr = wr; slvIdx = 0;
    reqValid = 1; reqAddr = baseAddr; reqSize = 2'(size);
    reqWrite = wr; reqWData = wd; portSel = 2'(port);
    @(negedge clk);
    chk(busy == 1, "R8 busy after accept", busy, 1);
    chk(busTs == 1, "R4 start one clock after accept", busTs, 1);
    // spurious request while busy must start nothing
    reqAddr = baseAddr + 32; reqSize = 2'b01; reqWrite = !wr;
    t = 1;
    @(negedge clk);
    reqValid = 0;
    t++;
    while (!done && t < 600) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1, "R7 done raised", done, 1);
    chk(busy == 0, "R8 busy low at done", busy, 0);
    chk(slvIdx == expN, "R2 cycle count", slvIdx, expN);
    if (fastMode)
      chk(t == (wr ? 3*expN : 2*expN + 1), "R9 fast termination timing",
          t, wr ? 3*expN : 2*expN + 1);
    if (!wr) chk(doneRData == expR, "R7 assembled read data", doneRData, expR);
    @(negedge clk);
    chk(done == 0, "R7 done single pulse", done, 0);
    chk(busy == 0 && busTs == 0, "R8 request while busy ignored", {busy, busTs}, 0);
    if (wr)
      for (int i = 0; i < n; i++)
        chk(mem[(baseAddr + i) & 63] == curData[i], "R6 written bytes",
            mem[(baseAddr + i) & 63], curData[i]);
    reqNo++;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 5) & 255);
    reqNo = 0; fastMode = 0; expN = 0; curPb = 4; curWr = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && busTs == 0 && done == 0, "R10 reset idle",
        {busy, busTs, done}, 0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && busTs == 0, "R10 idle after reset release", {busy, busTs}, 0);
    for (int f = 0; f < 2; f++) begin
      fastMode = (f == 1);
      for (int port = 0; port < 3; port++)
        for (int size = 0; size < 4; size++)
          for (int off = 0; off < 4; off++)
            for (int wr = 0; wr < 2; wr++)
              runReq(port, size, off, wr[0]);
    end
    summary();
    $finish;
  end
endmodule